// File: doc/BRIEF.md
# Logic Analyzer Probe Bank

This block sits between a management processor and a user design and gives the processor a set of probe channels. It can drive each channel toward the user design, sample it from the user design, or do both. There are 128 channels, split into four groups of 32. Each group has three registers on a simple word-addressed register bus: a data register, an output-enable mask and an input-enable mask.

The output mask is active low. A cleared bit lets the written data bit reach the user design, and it raises that channel's enable line toward the user. The input mask is active high. A set bit lets a read of the group's data register return the value the user design presents on that channel. Every channel is configured on its own, so any channel can be an output, an input, both, or neither.

The bank is intended to be configured, used to push a value or watch a count, and then released. The release is done by setting the output mask back to all ones, so that the user design's own logic takes over again.

Top module: `probe_bank`

## Requirements
- R1: A synchronous active-high reset clears every data register and input mask and sets every output mask to all ones. After reset, `user_out` and `user_drive_en` are zero, and a read of an output mask returns 0xFFFFFFFF.
- R2: Two clock edges after a write to the output mask of group g, `user_drive_en[32g+31:32g]` equals the bitwise inverse of the written mask. A read of that mask returns the written value.
- R3: Two clock edges after the data or output mask of group g changes, `user_out[32g+31:32g]` equals data AND NOT mask. A channel whose output is disabled drives 0.
- R4: A read of group g's data register returns `user_in[32g+31:32g]` AND the group's input mask, as sampled at the read edge. Channels whose input is disabled read 0.
- R5: The input and output settings of a channel are independent. A channel enabled both ways drives its written bit and also reads back the user value on that channel.
- R6: Register address = kind*4 + group. The kind is 0 for data, 1 for the output mask and 2 for the input mask. A write changes only the addressed register of the addressed group.
- R7: Addresses 12 to 15 are unmapped. Writes to them change no register, and reads from them return 0.
- R8: `bus_rvalid` is high in the cycle after each cycle with `bus_rd` high, and `bus_rdata` holds the read value there. When a read and a write hit the same mask register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| user_in | input | 128 | Values presented by the user design |
| user_out | output | 128 | Values driven toward the user design |
| user_drive_en | output | 128 | Per-channel drive enable toward the user design |

## Verification
A register write and a register read can land in the same cycle. They may hit the same mask register, or the write may change a mask while the read samples a data register under that mask. The bench provokes both cases with directed back-to-back accesses, then with long runs of random strobes in which reads and writes overlap freely while `user_in` changes every cycle. The behavioural model in the bench judges each result by the pre-write rule: the read takes the register state from before the edge. Drive outputs are judged at the same time, two edges after the write.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_OMASK = 2'd1,
    KIND_IMASK = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/probe_regfile.sv
module probe_regfile #(
  parameter int GROUP_W = 32,
  parameter int GSEL_W = 2,
  parameter int GROUP_IDX = 0,
  localparam int ADDR_W = GSEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [GROUP_W-1:0] wr_data,
  output logic [GROUP_W-1:0] data_q,
  output logic [GROUP_W-1:0] omask_q,
  output logic [GROUP_W-1:0] imask_q
);
  import probe_pkg::*;

  logic      hit;
  reg_kind_e kind;

  always_comb begin
    hit  = wr_en && (wr_addr[GSEL_W-1:0] == GSEL_W'(GROUP_IDX));
    kind = reg_kind_e'(wr_addr[ADDR_W-1:GSEL_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      omask_q <= '1;
      imask_q <= '0;
    end else if (hit) begin
      case (kind)
        KIND_DATA:  data_q  <= wr_data;
        KIND_OMASK: omask_q <= wr_data;
        KIND_IMASK: imask_q <= wr_data;
        default:    ;
      endcase
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_q == '0 && omask_q == '1 && imask_q == '0));

  // a write aimed at another group leaves this group untouched
  assert_other_group_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_addr[GSEL_W-1:0]) != GSEL_W'(GROUP_IDX))
      |-> ($stable(data_q) && $stable(omask_q) && $stable(imask_q)));

  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_addr[ADDR_W-1:GSEL_W]) == 2'd3)
      |-> ($stable(data_q) && $stable(omask_q) && $stable(imask_q)));
endmodule

// File: rtl/probe_gate.sv
module probe_gate #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] data_q,
  input  logic [GROUP_W-1:0] omask_q,
  output logic [GROUP_W-1:0] drive_q,
  output logic [GROUP_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      en_q    <= '0;
    end else begin
      drive_q <= data_q & ~omask_q;
      en_q    <= ~omask_q;
    end
  end

  assert_drive_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    (drive_q & ~en_q) == '0);

  assert_en_tracks_mask_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (en_q == ~$past(omask_q)));
endmodule

// File: rtl/probe_readmux.sv
module probe_readmux #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W = 32,
  localparam int GSEL_W = $clog2(NUM_GROUPS),
  localparam int ADDR_W = GSEL_W + 2,
  localparam int CH_W = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [CH_W-1:0]    omask_flat,
  input  logic [CH_W-1:0]    imask_flat,
  input  logic [CH_W-1:0]    user_in,
  output logic [GROUP_W-1:0] rdata_q,
  output logic               rvalid_q
);
  import probe_pkg::*;

  logic [GSEL_W-1:0]  grp;
  reg_kind_e          kind;
  logic [GROUP_W-1:0] sel;

  always_comb begin
    grp  = rd_addr[GSEL_W-1:0];
    kind = reg_kind_e'(rd_addr[ADDR_W-1:GSEL_W]);
    case (kind)
      KIND_DATA:  sel = user_in[grp*GROUP_W +: GROUP_W] & imask_flat[grp*GROUP_W +: GROUP_W];
      KIND_OMASK: sel = omask_flat[grp*GROUP_W +: GROUP_W];
      KIND_IMASK: sel = imask_flat[grp*GROUP_W +: GROUP_W];
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= sel;
    end
  end

  assert_rvalid_follows_rd_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rvalid_q == $past(rd_en)));

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(rd_addr[ADDR_W-1:GSEL_W]) == 2'd3)
      |-> (rdata_q == '0));

  assert_input_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(rd_addr[ADDR_W-1:GSEL_W]) == 2'd0)
      |-> ((rdata_q & ~$past(imask_flat[rd_addr[GSEL_W-1:0]*GROUP_W +: GROUP_W])) == '0));
endmodule

// File: rtl/probe_bank.sv
module probe_bank #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W = 32,
  localparam int GSEL_W = $clog2(NUM_GROUPS),
  localparam int ADDR_W = GSEL_W + 2,
  localparam int CH_W = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [GROUP_W-1:0] bus_wdata,
  output logic [GROUP_W-1:0] bus_rdata,
  output logic               bus_rvalid,
  input  logic [CH_W-1:0]    user_in,
  output logic [CH_W-1:0]    user_out,
  output logic [CH_W-1:0]    user_drive_en
);
  logic [CH_W-1:0] data_flat;
  logic [CH_W-1:0] omask_flat;
  logic [CH_W-1:0] imask_flat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    probe_regfile #(
      .GROUP_W  (GROUP_W),
      .GSEL_W   (GSEL_W),
      .GROUP_IDX(g)
    ) u_rf (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bus_wr),
      .wr_addr(bus_addr),
      .wr_data(bus_wdata),
      .data_q (data_flat[g*GROUP_W +: GROUP_W]),
      .omask_q(omask_flat[g*GROUP_W +: GROUP_W]),
      .imask_q(imask_flat[g*GROUP_W +: GROUP_W])
    );

    probe_gate #(
      .GROUP_W(GROUP_W)
    ) u_gate (
      .clk    (clk),
      .rst    (rst),
      .data_q (data_flat[g*GROUP_W +: GROUP_W]),
      .omask_q(omask_flat[g*GROUP_W +: GROUP_W]),
      .drive_q(user_out[g*GROUP_W +: GROUP_W]),
      .en_q   (user_drive_en[g*GROUP_W +: GROUP_W])
    );
  end

  probe_readmux #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_W   (GROUP_W)
  ) u_rmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd),
    .rd_addr   (bus_addr),
    .omask_flat(omask_flat),
    .imask_flat(imask_flat),
    .user_in   (user_in),
    .rdata_q   (bus_rdata),
    .rvalid_q  (bus_rvalid)
  );

  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (user_out == '0 && user_drive_en == '0 && bus_rvalid == 1'b0));
endmodule

// File: tb/probe_bank_bench.sv
module probe_bank_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [127:0] user_in = '0;
  logic [127:0] user_out;
  logic [127:0] user_drive_en;

  always #5 clk = ~clk;

  probe_bank u_probe_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .user_in(user_in), .user_out(user_out), .user_drive_en(user_drive_en)
  );

  int compared = 0;
  int mismatched = 0;
  string ph = "R1";

  logic [31:0]  m_data [4];
  logic [31:0]  m_om [4];
  logic [31:0]  m_im [4];
  logic [127:0] e_out = '0, e_en = '0;
  logic [31:0]  e_rdata = '0;
  logic         e_rvalid = 1'b0;

  function automatic logic [31:0] ref_read(logic [3:0] a, logic [127:0] ui);
    int g = int'(a[1:0]);
    case (a[3:2])
      2'd0:    return ui[g*32 +: 32] & m_im[g];
      2'd1:    return m_om[g];
      2'd2:    return m_im[g];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model as the posedge will, compare at next negedge
  task automatic step(bit r, bit wr, bit rd, logic [3:0] a, logic [31:0] wd, logic [127:0] ui);
    rst = r; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; user_in = ui;
    if (r) begin
      for (int g = 0; g < 4; g++) begin
        m_data[g] = '0; m_om[g] = '1; m_im[g] = '0;
      end
      e_out = '0; e_en = '0; e_rdata = '0; e_rvalid = 1'b0;
    end else begin
      for (int g = 0; g < 4; g++) begin
        e_out[g*32 +: 32] = m_data[g] & ~m_om[g];
        e_en[g*32 +: 32]  = ~m_om[g];
      end
      e_rvalid = rd;
      if (rd) e_rdata = ref_read(a, ui);
      if (wr) begin
        case (a[3:2])
          2'd0: m_data[a[1:0]] = wd;
          2'd1: m_om[a[1:0]] = wd;
          2'd2: m_im[a[1:0]] = wd;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({ph, " user_out R3"}, user_out, e_out);
    chk({ph, " user_drive_en R2"}, user_drive_en, e_en);
    chk({ph, " rvalid R8"}, {127'b0, bus_rvalid}, {127'b0, e_rvalid});
    if (e_rvalid) chk({ph, " rdata"}, {96'b0, bus_rdata}, {96'b0, e_rdata});
  endtask

  task automatic idle(int n, logic [127:0] ui);
    for (int i = 0; i < n; i++) step(0, 0, 0, 4'd0, 32'h0, ui);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [127:0] ui;
    @(negedge clk);
    ph = "R1";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 4'd0, 32'h0, '0);
    for (int a = 0; a < 12; a++) step(0, 0, 1, 4'(a), 32'h0, {4{32'hDEADBEEF}});
    idle(2, '0);

    ph = "R6";
    step(0, 1, 0, 4'd5, 32'h0000_0000, '0);
    step(0, 1, 0, 4'd1, 32'hA5A5_0F0F, '0);
    idle(3, '0);
    step(0, 0, 1, 4'd5, 32'h0, '0);
    step(0, 0, 1, 4'd4, 32'h0, '0);

    ph = "R2";
    step(0, 1, 0, 4'd6, 32'h00FF_00FF, '0);
    step(0, 1, 0, 4'd2, 32'h1234_5678, '0);
    idle(3, '0);

    ph = "R5";
    ui = {32'hCAFE_F00D, 32'h55AA_55AA, 32'h0F0F_F0F0, 32'h1111_2222};
    step(0, 1, 0, 4'd10, 32'h0FF0_0FF0, ui);
    step(0, 0, 1, 4'd2, 32'h0, ui);
    step(0, 0, 1, 4'd10, 32'h0, ui);
    idle(2, ui);

    ph = "R4";
    step(0, 0, 1, 4'd0, 32'h0, ui);
    step(0, 1, 0, 4'd8, 32'hFFFF_FFFF, ui);
    step(0, 0, 1, 4'd0, 32'h0, ui);
    step(0, 0, 1, 4'd3, 32'h0, ui);

    ph = "R8";
    step(0, 1, 1, 4'd7, 32'h0000_FFFF, ui);
    step(0, 0, 1, 4'd7, 32'h0, ui);
    step(0, 1, 1, 4'd11, 32'hF0F0_F0F0, ui);
    step(0, 1, 1, 4'd11, 32'h0F0F_0F0F, ui);
    step(0, 0, 1, 4'd11, 32'h0, ui);
    step(0, 1, 1, 4'd11, 32'h0000_00FF, ui);
    idle(3, ui);

    ph = "R7";
    for (int a = 12; a < 16; a++) step(0, 1, 0, 4'(a), 32'hFFFF_FFFF, ui);
    for (int a = 0; a < 16; a++) step(0, 0, 1, 4'(a), 32'h0, ui);
    idle(2, ui);

    ph = "R4 random";
    for (int i = 0; i < 4000; i++) begin
      ui = {$urandom, $urandom, $urandom, $urandom};
      step(0, 1'($urandom), 1'($urandom), 4'($urandom), $urandom, ui);
    end

    ph = "R1 mid-run";
    step(1, 0, 0, 4'd0, 32'h0, '0);
    for (int a = 4; a < 12; a++) step(0, 0, 1, 4'(a), 32'h0, '1);
    idle(2, '1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule